// File: doc/BRIEF.md
# Front-end hit burst filter

This block preselects the wire hits of one readout board for one event. A batch of hits is loaded over a valid/ready stream. Each hit carries a channel number, a TDC count, an ADC count and a dead-channel bit. Channels are grouped eight to an amplifier chip. The board has six chips, and the chip index is the channel number shifted right by three. Inside every chip the block looks for a burst of nearly simultaneous hits, which is the signature of crosstalk, and marks the hits in that burst for removal. The crosstalk search looks at the raw hits, before any other cut.

When all six chips have been searched, every hit gets a keep bit and an ADC-qualified bit. A hit is kept only when it is not part of a burst, its TDC lies in a fixed acceptance window, it passes an optional ADC threshold and it is not on a masked dead channel. The results stay at the outputs until the first hit of the next event is accepted. A one-cycle done pulse tells the consumer that the results can be read.

Top module: `hit_burst_filter`

## Requirements
- R1: While idle or loading, `inReady` is high and each beat with `inValid` high is stored at the next hit position, starting at 0. An event ends on the beat with `inLast` high, or on the sixteenth stored hit. From the cycle after that beat until the result cycle, `inReady` is low.
- R2: The chip index of a hit is `inChan >> 3`, and only chips 0 to 5 are searched. Hits on channels 48 to 63 are never flagged as crosstalk.
- R3: When `cfgXtEn` is set and a chip holds at least 4 hits, a group of 4 or more hits is a burst when the largest TDC minus the smallest TDC is at most 16. Every hit in that group is dropped. A span of 17 is not a burst. With `cfgXtEn` clear, no hit is dropped for crosstalk. Hits outside the TDC window still count towards a burst.
- R4: Only one burst is taken per chip. The search takes the largest group size first, then the group that starts at the lowest TDC. Hits outside that group are not dropped, even when they are close in time.
- R5: Only the first 8 hits of a chip, in load order, take part in its search. Later hits on that chip are never flagged and do not help form a burst.
- R6: A hit is dropped unless its TDC lies between 4450 and 4950. Both ends are included.
- R7: With `cfgAdcEn` set, a hit whose ADC is below `cfgAdcThr` is dropped. An ADC equal to the threshold passes.
- R8: With `cfgDeadEn` set, a hit with `inDead` high is dropped. With `cfgDeadEn` clear, the dead bit has no effect.
- R9: `qualVec[i]` is set only when hit i is kept and its ADC lies strictly between 10 and 10000.
- R10: `keepVec` and `qualVec` (bit i belongs to the i-th hit loaded) change to their final values 61 cycles after the last beat is accepted. `done` is high for exactly the following cycle. Positions with no hit read 0. The results hold until the first beat of the next event is accepted, which clears them.
- R11: The three enables and the threshold are captured with the first beat of an event. Changes to them later in the same event have no effect on that event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| inValid | input | 1 | Hit beat valid |
| inReady | output | 1 | Block accepts a hit beat |
| inLast | input | 1 | Beat is the last hit of the event |
| inChan | input | 6 | Front-end channel number |
| inTdc | input | 13 | TDC count of the hit |
| inAdc | input | 14 | ADC count of the hit |
| inDead | input | 1 | Channel is marked dead |
| cfgXtEn | input | 1 | Enable the crosstalk burst filter |
| cfgAdcEn | input | 1 | Enable the ADC threshold cut |
| cfgDeadEn | input | 1 | Enable the dead-channel mask |
| cfgAdcThr | input | 14 | ADC threshold for the cut |
| keepVec | output | 16 | Keep bit per loaded hit |
| qualVec | output | 16 | ADC-qualified bit per loaded hit |
| done | output | 1 | One-cycle pulse after the results become valid |

## Verification
Several properties are checked on every cycle:
- every chip's TDC list is in order when it reaches the search;
- a found burst never has fewer than four members;
- crosstalk flags change only on a search step or at the start of an event;
- the outputs hold between events;
- a qualified bit never appears without its keep bit;
- `done` lasts a single cycle.

Other behaviours show up only in the bench scenarios, which compare against a behavioural model:
- which group wins when several overlap;
- the 16 and 17 count span edge;
- the cap of eight hits per chip;
- the window and threshold ends;
- capture of the configuration with the first beat.

// File: rtl/hbf_pkg.sv
package hbf_pkg;

  // Control-to-datapath strobes, one bit each
  typedef struct packed {
    logic newEvent;  // first beat of an event: clear results, capture config
    logic load;      // store the current beat
    logic gather;    // collect one chip's hits into the sort slots
    logic sortStep;  // one compare-exchange phase
    logic sortOdd;   // phase parity: pairs (1,2),(3,4).. when set
    logic search;    // find the burst and mark its hits
    logic finish;    // write keep and qualified bits
  } hbf_strobe_t;

endpackage

// File: rtl/hbf_burst_search.sv
module hbf_burst_search #(
  parameter int SLOTS     = 8,
  parameter int TDC_W     = 13,
  parameter int MIN_BURST = 4,
  parameter int SPAN      = 16,
  parameter int SCNT_W    = 4
) (
  input  logic [SLOTS-1:0][TDC_W-1:0] sortTdc,
  input  logic [SCNT_W-1:0]           slotCnt,
  output logic [SLOTS-1:0]            burstMask
);

  logic found;

  // Largest group first, then the earliest start within a size
  always_comb begin
    burstMask = '0;
    found     = 1'b0;
    for (int n = SLOTS; n >= MIN_BURST; n--) begin
      for (int k = 0; k + n <= SLOTS; k++) begin
        if (!found && (k + n) <= int'(slotCnt) &&
            (sortTdc[k+n-1] - sortTdc[k]) <= TDC_W'(SPAN)) begin
          found = 1'b1;
          for (int b = 0; b < SLOTS; b++) begin
            if (b >= k && b < k + n) burstMask[b] = 1'b1;
          end
        end
      end
    end
  end

endmodule

// File: rtl/hbf_ctrl.sv
module hbf_ctrl
  import hbf_pkg::*;
#(
  parameter int MAX_HITS = 16,
  parameter int ASICS    = 6,
  parameter int ASIC_W   = 3,
  parameter int SLOTS    = 8
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  logic                        inValid,
  input  logic                        inLast,
  output logic                        inReady,
  output hbf_strobe_t                 stb,
  output logic [$clog2(MAX_HITS)-1:0] wrIdx,
  output logic [ASIC_W-1:0]           asicSel,
  output logic                        done
);

  localparam int IDX_W = $clog2(MAX_HITS);
  localparam int CNT_W = $clog2(MAX_HITS + 1);
  localparam int PH_W  = $clog2(SLOTS);

  typedef enum logic [2:0] {
    ST_IDLE, ST_LOAD, ST_GATHER, ST_SORT, ST_SEARCH, ST_FINAL, ST_POST
  } state_t;

  state_t            state, nextState;
  logic [CNT_W-1:0]  hitCnt;
  logic [PH_W-1:0]   phase;

  always_comb begin
    stb       = '0;
    inReady   = 1'b0;
    wrIdx     = hitCnt[IDX_W-1:0];
    nextState = state;
    case (state)
      ST_IDLE: begin
        inReady = 1'b1;
        wrIdx   = '0;
        if (inValid) begin
          stb.newEvent = 1'b1;
          stb.load     = 1'b1;
          nextState    = (inLast || MAX_HITS == 1) ? ST_GATHER : ST_LOAD;
        end
      end
      ST_LOAD: begin
        inReady = 1'b1;
        if (inValid) begin
          stb.load = 1'b1;
          if (inLast || hitCnt == CNT_W'(MAX_HITS - 1)) nextState = ST_GATHER;
        end
      end
      ST_GATHER: begin
        stb.gather = 1'b1;
        nextState  = ST_SORT;
      end
      ST_SORT: begin
        stb.sortStep = 1'b1;
        stb.sortOdd  = phase[0];
        if (phase == PH_W'(SLOTS - 1)) nextState = ST_SEARCH;
      end
      ST_SEARCH: begin
        stb.search = 1'b1;
        nextState  = (asicSel == ASIC_W'(ASICS - 1)) ? ST_FINAL : ST_GATHER;
      end
      ST_FINAL: begin
        stb.finish = 1'b1;
        nextState  = ST_POST;
      end
      default: nextState = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      hitCnt  <= '0;
      phase   <= '0;
      asicSel <= '0;
      done    <= 1'b0;
    end else begin
      state <= nextState;
      done  <= (state == ST_POST);
      if (stb.load) hitCnt <= stb.newEvent ? CNT_W'(1) : hitCnt + CNT_W'(1);
      if (stb.gather) phase <= '0;
      else if (stb.sortStep) phase <= phase + PH_W'(1);
      if (stb.newEvent) asicSel <= '0;
      else if (stb.search && asicSel != ASIC_W'(ASICS - 1)) asicSel <= asicSel + ASIC_W'(1);
    end
  end

  // R1
  load_stop_chk: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && inReady && inLast) |=> !inReady);

  // R1
  load_cap_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_LOAD) |-> (hitCnt < CNT_W'(MAX_HITS)));

  // R10
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

endmodule

// File: rtl/hbf_dp.sv
module hbf_dp
  import hbf_pkg::*;
#(
  parameter int MAX_HITS  = 16,
  parameter int CHAN_W    = 6,
  parameter int TDC_W     = 13,
  parameter int ADC_W     = 14,
  parameter int ASIC_W    = 3,
  parameter int SLOTS     = 8,
  parameter int MIN_BURST = 4,
  parameter int SPAN      = 16,
  parameter int WIN_LO    = 4450,
  parameter int WIN_HI    = 4950,
  parameter int FLAG_LO   = 10,
  parameter int FLAG_HI   = 10000
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  hbf_strobe_t                 stb,
  input  logic [$clog2(MAX_HITS)-1:0] wrIdx,
  input  logic [ASIC_W-1:0]           asicSel,
  input  logic [CHAN_W-1:0]           inChan,
  input  logic [TDC_W-1:0]            inTdc,
  input  logic [ADC_W-1:0]            inAdc,
  input  logic                        inDead,
  input  logic                        cfgXtEn,
  input  logic                        cfgAdcEn,
  input  logic                        cfgDeadEn,
  input  logic [ADC_W-1:0]            cfgAdcThr,
  output logic [MAX_HITS-1:0]         keepVec,
  output logic [MAX_HITS-1:0]         qualVec
);

  localparam int IDX_W  = $clog2(MAX_HITS);
  localparam int SLOT_W = $clog2(SLOTS);
  localparam int SCNT_W = $clog2(SLOTS + 1);
  localparam int SH     = CHAN_W - ASIC_W;

  // Hit store
  logic [MAX_HITS-1:0][CHAN_W-1:0] hChan;
  logic [MAX_HITS-1:0][TDC_W-1:0]  hTdc;
  logic [MAX_HITS-1:0][ADC_W-1:0]  hAdc;
  logic [MAX_HITS-1:0]             hDead, hVal, xtFlag;

  // Captured config
  logic             xtEnQ, adcEnQ, deadEnQ;
  logic [ADC_W-1:0] thrQ;

  // Sort slots
  logic [SLOTS-1:0][TDC_W-1:0] sTdc, gTdc, nTdc;
  logic [SLOTS-1:0][IDX_W-1:0] sIdx, gIdx, nIdx;
  logic [SLOTS-1:0]            sVal, gVal, nVal;
  logic [SCNT_W-1:0]           sCnt, gCnt;
  logic [SLOTS-1:0]            burstMask;
  logic [MAX_HITS-1:0]         keepNext, qualNext;

  // Compact the selected chip's hits, in load order, into the slots
  always_comb begin
    gTdc = '1;
    gIdx = '0;
    gVal = '0;
    gCnt = '0;
    for (int i = 0; i < MAX_HITS; i++) begin
      if (hVal[i] && hChan[i][CHAN_W-1:SH] == asicSel && gCnt < SCNT_W'(SLOTS)) begin
        gTdc[gCnt[SLOT_W-1:0]] = hTdc[i];
        gIdx[gCnt[SLOT_W-1:0]] = IDX_W'(i);
        gVal[gCnt[SLOT_W-1:0]] = 1'b1;
        gCnt = gCnt + SCNT_W'(1);
      end
    end
  end

  // One odd-even transposition phase; swap only on strict order so ties keep load order
  always_comb begin
    nTdc = sTdc;
    nIdx = sIdx;
    nVal = sVal;
    for (int j = 0; j < SLOTS - 1; j++) begin
      if ((((j % 2) == 1) == stb.sortOdd) && sTdc[j] > sTdc[j+1]) begin
        nTdc[j] = sTdc[j+1]; nTdc[j+1] = sTdc[j];
        nIdx[j] = sIdx[j+1]; nIdx[j+1] = sIdx[j];
        nVal[j] = sVal[j+1]; nVal[j+1] = sVal[j];
      end
    end
  end

  hbf_burst_search #(
    .SLOTS(SLOTS), .TDC_W(TDC_W), .MIN_BURST(MIN_BURST), .SPAN(SPAN), .SCNT_W(SCNT_W)
  ) search_i (
    .sortTdc(sTdc), .slotCnt(sCnt), .burstMask(burstMask)
  );

  // Final cuts per hit
  always_comb begin
    for (int i = 0; i < MAX_HITS; i++) begin
      keepNext[i] = hVal[i] && !xtFlag[i] &&
                    hTdc[i] >= TDC_W'(WIN_LO) && hTdc[i] <= TDC_W'(WIN_HI) &&
                    (!adcEnQ || hAdc[i] >= thrQ) &&
                    (!deadEnQ || !hDead[i]);
      qualNext[i] = keepNext[i] && hAdc[i] > ADC_W'(FLAG_LO) && hAdc[i] < ADC_W'(FLAG_HI);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      hChan <= '0; hTdc <= '0; hAdc <= '0; hDead <= '0; hVal <= '0; xtFlag <= '0;
      xtEnQ <= 1'b0; adcEnQ <= 1'b0; deadEnQ <= 1'b0; thrQ <= '0;
      sTdc <= '1; sIdx <= '0; sVal <= '0; sCnt <= '0;
      keepVec <= '0; qualVec <= '0;
    end else begin
      if (stb.newEvent) begin
        hVal    <= '0;
        xtFlag  <= '0;
        keepVec <= '0;
        qualVec <= '0;
        xtEnQ   <= cfgXtEn;
        adcEnQ  <= cfgAdcEn;
        deadEnQ <= cfgDeadEn;
        thrQ    <= cfgAdcThr;
      end
      if (stb.load) begin
        hChan[wrIdx] <= inChan;
        hTdc[wrIdx]  <= inTdc;
        hAdc[wrIdx]  <= inAdc;
        hDead[wrIdx] <= inDead;
        hVal[wrIdx]  <= 1'b1;
      end
      if (stb.gather) begin
        sTdc <= gTdc; sIdx <= gIdx; sVal <= gVal; sCnt <= gCnt;
      end else if (stb.sortStep) begin
        sTdc <= nTdc; sIdx <= nIdx; sVal <= nVal;
      end
      if (stb.search && xtEnQ) begin
        for (int j = 0; j < SLOTS; j++) begin
          if (burstMask[j] && sVal[j]) xtFlag[sIdx[j]] <= 1'b1;
        end
      end
      if (stb.finish) begin
        keepVec <= keepNext;
        qualVec <= qualNext;
      end
    end
  end

  // Order of the sorted slots, for the check below
  logic sortedOk;
  always_comb begin
    sortedOk = 1'b1;
    for (int j = 0; j < SLOTS - 1; j++) begin
      if (sVal[j+1] && sTdc[j] > sTdc[j+1]) sortedOk = 1'b0;
    end
  end

  // R3
  sort_order_chk: assert property (@(posedge clk) disable iff (!rstN)
    stb.search |-> sortedOk);

  // R4
  burst_size_chk: assert property (@(posedge clk) disable iff (!rstN)
    stb.search |-> (burstMask == '0 || $countones(burstMask) >= MIN_BURST));

  // R3
  flag_write_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!stb.search && !stb.newEvent) |=> $stable(xtFlag));

  // R9
  qual_sub_chk: assert property (@(posedge clk) disable iff (!rstN)
    (qualVec & ~keepVec) == '0);

  // R10
  keep_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!stb.finish && !stb.newEvent) |=> $stable(keepVec));

endmodule

// File: rtl/hit_burst_filter.sv
module hit_burst_filter
  import hbf_pkg::*;
#(
  parameter int MAX_HITS    = 16,
  parameter int CHAN_W      = 6,
  parameter int TDC_W       = 13,
  parameter int ADC_W       = 14,
  parameter int CH_PER_ASIC = 8,
  parameter int ASICS       = 6,
  parameter int SLOTS       = 8,
  parameter int MIN_BURST   = 4,
  parameter int SPAN        = 16,
  parameter int WIN_LO      = 4450,
  parameter int WIN_HI      = 4950,
  parameter int FLAG_LO     = 10,
  parameter int FLAG_HI     = 10000
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                inValid,
  output logic                inReady,
  input  logic                inLast,
  input  logic [CHAN_W-1:0]   inChan,
  input  logic [TDC_W-1:0]    inTdc,
  input  logic [ADC_W-1:0]    inAdc,
  input  logic                inDead,
  input  logic                cfgXtEn,
  input  logic                cfgAdcEn,
  input  logic                cfgDeadEn,
  input  logic [ADC_W-1:0]    cfgAdcThr,
  output logic [MAX_HITS-1:0] keepVec,
  output logic [MAX_HITS-1:0] qualVec,
  output logic                done
);

  localparam int ASIC_W = CHAN_W - $clog2(CH_PER_ASIC);
  localparam int IDX_W  = $clog2(MAX_HITS);

  hbf_strobe_t        stb;
  logic [IDX_W-1:0]   wrIdx;
  logic [ASIC_W-1:0]  asicSel;

  hbf_ctrl #(
    .MAX_HITS(MAX_HITS), .ASICS(ASICS), .ASIC_W(ASIC_W), .SLOTS(SLOTS)
  ) ctrl_i (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inLast(inLast), .inReady(inReady),
    .stb(stb), .wrIdx(wrIdx), .asicSel(asicSel), .done(done)
  );

  hbf_dp #(
    .MAX_HITS(MAX_HITS), .CHAN_W(CHAN_W), .TDC_W(TDC_W), .ADC_W(ADC_W),
    .ASIC_W(ASIC_W), .SLOTS(SLOTS), .MIN_BURST(MIN_BURST), .SPAN(SPAN),
    .WIN_LO(WIN_LO), .WIN_HI(WIN_HI), .FLAG_LO(FLAG_LO), .FLAG_HI(FLAG_HI)
  ) dp_i (
    .clk(clk), .rstN(rstN), .stb(stb), .wrIdx(wrIdx), .asicSel(asicSel),
    .inChan(inChan), .inTdc(inTdc), .inAdc(inAdc), .inDead(inDead),
    .cfgXtEn(cfgXtEn), .cfgAdcEn(cfgAdcEn), .cfgDeadEn(cfgDeadEn), .cfgAdcThr(cfgAdcThr),
    .keepVec(keepVec), .qualVec(qualVec)
  );

  // R10
  done_valid_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |-> $stable(keepVec) && $stable(qualVec));

endmodule

// File: tb/hit_burst_filter_tb.sv
`timescale 1ns/1ps
module hit_burst_filter_tb_top;

  localparam int MAXH    = 16;
  localparam int LATENCY = 62;  // cycles from last accepted beat to the done cycle

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        inValid = 1'b0, inLast = 1'b0, inDead = 1'b0;
  logic        inReady;
  logic [5:0]  inChan = '0;
  logic [12:0] inTdc = '0;
  logic [13:0] inAdc = '0;
  logic        cfgXtEn = 1'b1, cfgAdcEn = 1'b0, cfgDeadEn = 1'b0;
  logic [13:0] cfgAdcThr = '0;
  logic [MAXH-1:0] keepVec, qualVec;
  logic        done;

  always #2.5 clk = ~clk;

  hit_burst_filter dut_i (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inReady(inReady), .inLast(inLast),
    .inChan(inChan), .inTdc(inTdc), .inAdc(inAdc), .inDead(inDead),
    .cfgXtEn(cfgXtEn), .cfgAdcEn(cfgAdcEn), .cfgDeadEn(cfgDeadEn), .cfgAdcThr(cfgAdcThr),
    .keepVec(keepVec), .qualVec(qualVec), .done(done)
  );

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;
  int cyc = 0;

  // Event under test
  int eChan[MAXH], eTdc[MAXH], eAdc[MAXH];
  bit eDead[MAXH];
  int eN = 0;
  bit mXt, mAdc, mDead;
  int mThr;
  logic [MAXH-1:0] expKeep = '0, expQual = '0;

  task automatic chk(bit ok, string req, string what, longint act, longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic clearEv();
    eN = 0;
  endtask

  task automatic addHit(int c, int t, int a, bit d);
    eChan[eN] = c; eTdc[eN] = t; eAdc[eN] = a; eDead[eN] = d;
    eN++;
  endtask

  task automatic setCfg(bit xt, bit ac, bit dd, int thr);
    cfgXtEn = xt; cfgAdcEn = ac; cfgDeadEn = dd; cfgAdcThr = 14'(thr);
  endtask

  // Behavioural reference for one event
  function automatic void computeExpected();
    bit xt[MAXH];
    for (int i = 0; i < MAXH; i++) xt[i] = 1'b0;
    for (int a = 0; a < 6; a++) begin
      int q[$];
      bit found;
      found = 1'b0;
      for (int i = 0; i < eN; i++)
        if (eChan[i] / 8 == a && q.size() < 8) q.push_back(i);
      if (mXt && q.size() >= 4) begin
        for (int x = 1; x < q.size(); x++) begin
          int y;
          y = x;
          while (y > 0 && eTdc[q[y-1]] > eTdc[q[y]]) begin
            int t;
            t = q[y]; q[y] = q[y-1]; q[y-1] = t;
            y--;
          end
        end
        for (int n = q.size(); n >= 4 && !found; n--)
          for (int k = 0; k + n <= q.size() && !found; k++)
            if (eTdc[q[k+n-1]] - eTdc[q[k]] <= 16) begin
              found = 1'b1;
              for (int b = k; b < k + n; b++) xt[q[b]] = 1'b1;
            end
      end
    end
    expKeep = '0;
    expQual = '0;
    for (int i = 0; i < eN; i++) begin
      bit k;
      k = !xt[i] && eTdc[i] >= 4450 && eTdc[i] <= 4950 &&
          (!mAdc || eAdc[i] >= mThr) && (!mDead || !eDead[i]);
      expKeep[i] = k;
      expQual[i] = k && eAdc[i] > 10 && eAdc[i] < 10000;
    end
  endfunction

  // Sends the event, then compares ready, done and results on every cycle
  task automatic runEvent(string req, bit useLast, bit flipCfg);
    // R10: previous results still held before the new event
    chk(keepVec == expKeep, "R10", "keep held before next event", keepVec, expKeep);
    chk(qualVec == expQual, "R10", "qual held before next event", qualVec, expQual);
    mXt = cfgXtEn; mAdc = cfgAdcEn; mDead = cfgDeadEn; mThr = int'(cfgAdcThr);
    for (int i = 0; i < eN; i++) begin
      @(negedge clk);
      if (i == 1) begin
        // R10: results cleared by the first beat
        chk(keepVec == '0 && qualVec == '0, "R10", "results cleared on first beat", keepVec, 0);
        if (flipCfg) setCfg(!mXt, !mAdc, !mDead, 9000);
      end
      chk(inReady == 1'b1, "R1", "ready while loading", inReady, 1);
      inValid = 1'b1;
      inChan = 6'(eChan[i]); inTdc = 13'(eTdc[i]); inAdc = 14'(eAdc[i]); inDead = eDead[i];
      inLast = useLast && (i == eN - 1);
      @(posedge clk);
    end
    computeExpected();
    for (int k = 0; k <= LATENCY + 1; k++) begin
      @(negedge clk);
      inValid = 1'b0; inLast = 1'b0;
      chk(inReady == (k >= LATENCY), "R1", $sformatf("ready at cycle %0d", k), inReady, k >= LATENCY);
      chk(done == (k == LATENCY), "R10", $sformatf("done at cycle %0d", k), done, k == LATENCY);
      if (k == LATENCY) begin
        chk(keepVec == expKeep, req, "keep bits", keepVec, expKeep);
        chk(qualVec == expQual, req, "qualified bits", qualVec, expQual);
      end
    end
    if (flipCfg) setCfg(mXt, mAdc, mDead, mThr);
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // Reset state (R1, R10)
    chk(done == 1'b0, "R10", "done in reset", done, 0);
    chk(keepVec == '0 && qualVec == '0, "R10", "results in reset", keepVec, 0);
    chk(inReady == 1'b1, "R1", "ready in reset", inReady, 1);
    rstN = 1'b1;
    repeat (2) @(negedge clk);

    // R3: four hits in chip 0 spanning exactly 16, plus a lone hit in chip 1
    setCfg(1, 0, 0, 0);
    clearEv();
    addHit(0, 4600, 200, 0); addHit(1, 4605, 200, 0); addHit(9, 4700, 200, 0);
    addHit(2, 4610, 200, 0); addHit(3, 4616, 200, 0);
    runEvent("R3", 1, 0);

    // R3: span 17 is not a burst
    clearEv();
    addHit(0, 4600, 200, 0); addHit(1, 4605, 200, 0);
    addHit(2, 4610, 200, 0); addHit(3, 4617, 200, 0);
    runEvent("R3", 1, 0);

    // R3: filter disabled keeps a real burst
    setCfg(0, 0, 0, 0);
    clearEv();
    addHit(0, 4600, 200, 0); addHit(1, 4605, 200, 0);
    addHit(2, 4610, 200, 0); addHit(3, 4616, 200, 0);
    runEvent("R3", 1, 0);

    // R3: hits outside the window still form a burst
    setCfg(1, 0, 0, 0);
    clearEv();
    addHit(40, 4440, 200, 0); addHit(41, 4445, 200, 0);
    addHit(42, 4451, 200, 0); addHit(43, 4455, 200, 0);
    runEvent("R3", 1, 0);

    // R4: five of six hits form the largest burst; the sixth survives
    clearEv();
    addHit(16, 4530, 300, 0); addHit(17, 4500, 300, 0); addHit(18, 4515, 300, 0);
    addHit(19, 4503, 300, 0); addHit(20, 4510, 300, 0); addHit(21, 4506, 300, 0);
    runEvent("R4", 1, 0);

    // R4: two disjoint groups of four; only the earlier one is dropped
    clearEv();
    addHit(24, 4600, 300, 0); addHit(25, 4601, 300, 0); addHit(26, 4602, 300, 0);
    addHit(27, 4603, 300, 0); addHit(28, 4800, 300, 0); addHit(29, 4801, 300, 0);
    addHit(30, 4802, 300, 0); addHit(31, 4803, 300, 0);
    runEvent("R4", 1, 0);

    // R2: a burst on channels 48..51 is not searched; three hits are too few
    clearEv();
    addHit(48, 4700, 300, 0); addHit(49, 4701, 300, 0);
    addHit(50, 4702, 300, 0); addHit(51, 4703, 300, 0);
    addHit(24, 4700, 300, 0); addHit(25, 4701, 300, 0); addHit(26, 4702, 300, 0);
    runEvent("R2", 1, 0);

    // R5: the ninth and tenth hits of chip 4 would complete a burst but are ignored
    clearEv();
    addHit(32, 4600, 300, 0); addHit(33, 4601, 300, 0); addHit(34, 4602, 300, 0);
    addHit(35, 4700, 300, 0); addHit(36, 4750, 300, 0); addHit(37, 4800, 300, 0);
    addHit(38, 4850, 300, 0); addHit(39, 4900, 300, 0);
    addHit(32, 4603, 300, 0); addHit(33, 4604, 300, 0);
    runEvent("R5", 1, 0);

    // R6: window edges, one hit per chip
    clearEv();
    addHit(0, 4449, 300, 0); addHit(8, 4450, 300, 0);
    addHit(16, 4950, 300, 0); addHit(24, 4951, 300, 0);
    runEvent("R6", 1, 0);

    // R7: threshold edge
    setCfg(1, 1, 0, 100);
    clearEv();
    addHit(0, 4600, 99, 0); addHit(8, 4600, 100, 0); addHit(16, 4600, 101, 0);
    runEvent("R7", 1, 0);

    // R8: dead mask on, then off
    setCfg(1, 0, 1, 0);
    clearEv();
    addHit(0, 4600, 300, 1); addHit(8, 4600, 300, 0);
    runEvent("R8", 1, 0);
    setCfg(1, 0, 0, 0);
    runEvent("R8", 1, 0);

    // R9: qualified bit limits, and none for a dropped hit
    clearEv();
    addHit(0, 4600, 10, 0); addHit(8, 4600, 11, 0); addHit(16, 4600, 9999, 0);
    addHit(24, 4600, 10000, 0); addHit(32, 4400, 500, 0);
    runEvent("R9", 1, 0);

    // R11: config flipped after the first beat has no effect
    setCfg(0, 0, 0, 0);
    clearEv();
    addHit(0, 4600, 50, 1); addHit(1, 4601, 50, 1);
    addHit(2, 4602, 50, 0); addHit(3, 4603, 50, 0);
    runEvent("R11", 1, 1);

    // R1: full batch of sixteen ends without a last flag
    setCfg(1, 0, 0, 0);
    clearEv();
    for (int i = 0; i < MAXH; i++) addHit((i * 3) % 48, 4460 + ((i * 37) % 500), 20 + i * 700, 0);
    runEvent("R1", 0, 0);

    // R10: a single-hit event leaves the other positions at zero
    clearEv();
    addHit(5, 4700, 400, 0);
    runEvent("R10", 1, 0);

    if (!finished) begin
      finished = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000 && !finished) begin
      finished = 1'b1;
      checks++;
      errors++;
      $display("FAIL R1 watchdog: actual %0d cycles expected completion", cyc);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule